// File: doc/BRIEF.md
# Multi-channel serial interrupt aggregator

This block collects the interrupt request levels of a card's serial channels and folds them into one level-sensitive interrupt line for the host. Channels are organised in groups of sixteen. Each group owns a live status view of its sixteen request lines, a mask register in which a set bit blocks the matching channel, a pending view (requests that survive the mask) and a group enable. A single global enable sits above all groups, so the output fires only when the card is enabled, the group is enabled and at least one unmasked channel of that group is requesting.

Software reaches every register over a simple synchronous write, combinational read bus. Groups sit 0x1000 bytes apart, so a two-group (32-channel) card presents two identical register windows that share one output line; the pending view lets the interrupt handler walk channels in index order. Request clearing is the channels' own business: the status view is read-only and follows the request inputs.

Top module: `uart_irq_aggregator`

## Requirements
- R1: Each group serves 16 channels; reading group offset 0x000 returns the live request levels of its channels in bits 15:0 (channel n in bit n), upper bits zero.
- R2: Group offset 0x004 is the mask register; bit n set blocks channel n, bit n clear lets it through, and a read returns the last value written to bits 15:0.
- R3: After reset every mask reads 0xFFFF, every group enable reads 0, the global enable reads 0 and the interrupt output is low.
- R4: Group offset 0x008 reads the pending set, equal to the live requests ANDed with the inverse of the mask.
- R5: Group offset 0x00C is the group control register; only bit 20 (group enable) is stored, every other bit is ignored on write and reads 0.
- R6: Address 0xF000 is the global enable register; only bit 0 is stored and it reads back in bit 0.
- R7: The interrupt output is high exactly when the global enable is set and some group has its enable set with a nonzero pending set; it follows request changes in the same cycle, without a clock edge.
- R8: Group g occupies addresses g*0x1000 to g*0x1000+0xFFF (address bits 15:12 select the group); a write to one group's registers leaves every other group unchanged, and writes to the status or pending offsets change nothing.
- R9: Reads of offsets other than the four above, of group indices at or beyond the group count, and of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_req | input | 32 | Request level per channel, channel 16*g+n is bit n of group g |
| bus_wr | input | 1 | Write strobe, register updated at the rising edge |
| bus_addr | input | 16 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Shared level-sensitive interrupt line |

## Verification
Read data and the interrupt line are combinational, so they are due in the same cycle as a change on chan_req or bus_addr; the bench drives inputs on the falling edge and samples one nanosecond later, well before the next rising edge. A write takes effect at the following rising edge, so the bench's reference registers are updated only after the same-cycle checks and the effect is first compared at the next falling edge. Reset release passes a two-stage synchroniser, so the reset-state checks wait several cycles after rst_n rises.

// File: rtl/uart_irq_agg_pkg.sv
package uart_irq_agg_pkg;
  localparam int unsigned CH_PER_GRP  = 16;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned OFS_W       = 12;
  localparam int unsigned GRP_IDX_W   = ADDR_W - OFS_W;
  localparam int unsigned GRP_EN_BIT  = 20;
  localparam int unsigned GLB_EN_BIT  = 0;

  localparam logic [OFS_W-1:0]  OFS_STATUS = 12'h000;
  localparam logic [OFS_W-1:0]  OFS_MASK   = 12'h004;
  localparam logic [OFS_W-1:0]  OFS_PEND   = 12'h008;
  localparam logic [OFS_W-1:0]  OFS_CTRL   = 12'h00C;
  localparam logic [ADDR_W-1:0] ADDR_GLB   = 16'hF000;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irq_chan_group.sv
module irq_chan_group
  import uart_irq_agg_pkg::*;
#(
  parameter int unsigned CH = CH_PER_GRP,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned OW = OFS_W,
  parameter int unsigned EN_BIT = GRP_EN_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] req,
  input  logic          wr_en,
  input  logic [OW-1:0] ofs,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          grp_irq
);
  logic [CH-1:0] mask_q, mask_d;
  logic          mask_we;
  logic          blk_en_q, blk_en_d;
  logic          blk_en_we;
  logic [CH-1:0] pend;
  logic          unused_wdata;

  assign unused_wdata = ^wdata;

  // next-state
  always_comb begin
    mask_we   = wr_en && (ofs == OFS_MASK);
    mask_d    = wdata[CH-1:0];
    blk_en_we = wr_en && (ofs == OFS_CTRL);
    blk_en_d  = wdata[EN_BIT];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         blk_en_q <= 1'b0;
    else if (blk_en_we) blk_en_q <= blk_en_d;
  end

  assign pend    = req & ~mask_q;
  assign grp_irq = blk_en_q & (|pend);

  always_comb begin
    rdata = '0;
    case (ofs)
      OFS_STATUS: rdata[CH-1:0] = req;
      OFS_MASK:   rdata[CH-1:0] = mask_q;
      OFS_PEND:   rdata[CH-1:0] = pend;
      OFS_CTRL:   rdata[EN_BIT] = blk_en_q;
      default:    rdata = '0;
    endcase
  end

  // a mask of all ones silences the group from the next cycle on
  assert_full_mask_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ofs == OFS_MASK && wdata[CH-1:0] == '1) |=> !grp_irq);

  // clearing the group enable silences the group from the next cycle on
  assert_grp_disable_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ofs == OFS_CTRL && !wdata[EN_BIT]) |=> !grp_irq);

  // writes to the read-only views leave the stored state alone
  assert_ro_view_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (ofs == OFS_STATUS || ofs == OFS_PEND)) |=> ($stable(mask_q) && $stable(blk_en_q)));

  // a written mask is what the register holds afterwards
  assert_mask_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ofs == OFS_MASK) |=> (mask_q == $past(wdata[CH-1:0])));
endmodule

// File: rtl/irq_global_ctrl.sv
module irq_global_ctrl
  import uart_irq_agg_pkg::*;
#(
  parameter int unsigned NG = 2,
  parameter int unsigned EN_BIT = GLB_EN_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic [NG-1:0] grp_irq,
  output logic          glb_en,
  output logic          irq_out
);
  logic glb_en_q, glb_en_d;

  always_comb glb_en_d = wr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     glb_en_q <= 1'b0;
    else if (wr_en) glb_en_q <= glb_en_d;
  end

  assign glb_en  = glb_en_q;
  assign irq_out = glb_en_q & (|grp_irq);

  // clearing the global enable drops the line from the next cycle on
  assert_glb_disable_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_bit) |=> !irq_out);

  // the line is only ever raised on behalf of some group
  assert_line_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|grp_irq));
endmodule

// File: rtl/uart_irq_aggregator.sv
module uart_irq_aggregator
  import uart_irq_agg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 2,
  localparam int unsigned NCH = NUM_GROUPS * CH_PER_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic                  rst_sync_n;
  logic                  glb_hit;
  logic                  glb_en;
  logic [NUM_GROUPS-1:0] grp_hit;
  logic [NUM_GROUPS-1:0] grp_irq;
  logic [DATA_W-1:0]     grp_rdata [NUM_GROUPS];

  irq_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign glb_hit = (bus_addr == ADDR_GLB);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_hit[g] = !glb_hit && (bus_addr[ADDR_W-1:OFS_W] == GRP_IDX_W'(g));

    irq_chan_group #(
      .CH     (CH_PER_GRP),
      .DW     (DATA_W),
      .OW     (OFS_W),
      .EN_BIT (GRP_EN_BIT)
    ) i_group (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .req     (chan_req[g*CH_PER_GRP +: CH_PER_GRP]),
      .wr_en   (bus_wr && grp_hit[g]),
      .ofs     (bus_addr[OFS_W-1:0]),
      .wdata   (bus_wdata),
      .rdata   (grp_rdata[g]),
      .grp_irq (grp_irq[g])
    );
  end

  irq_global_ctrl #(
    .NG     (NUM_GROUPS),
    .EN_BIT (GLB_EN_BIT)
  ) i_global (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (bus_wr && glb_hit),
    .wr_bit  (bus_wdata[GLB_EN_BIT]),
    .grp_irq (grp_irq),
    .glb_en  (glb_en),
    .irq_out (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (glb_hit) bus_rdata[GLB_EN_BIT] = glb_en;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp_hit[g]) bus_rdata = grp_rdata[g];
    end
  end

  // at most one register window answers an address
  assert_one_window_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({glb_hit, grp_hit}));

  // the line never rises while the card-wide enable is off
  assert_no_irq_when_off_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !glb_en |-> !irq_out);
endmodule

// File: tb/test_uart_irq_aggregator.sv
module test_uart_irq_aggregator;
  localparam int NG  = 2;
  localparam int NCH = NG * 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  chan_req = '0;
  logic            bus_wr = 1'b0;
  logic [15:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            irq_out;

  int unsigned vectors = 0;
  int unsigned errs = 0;
  bit          done = 1'b0;

  logic [15:0] m_mask [NG];
  logic        m_ctl  [NG];
  logic        m_glb;

  always #10 clk = ~clk;

  uart_irq_aggregator #(.NUM_GROUPS(NG)) i_uart_irq_aggregator (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_req  (chan_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  function automatic logic exp_irq(input logic [NCH-1:0] rq);
    logic any = 1'b0;
    for (int g = 0; g < NG; g++)
      if (m_ctl[g] && ((rq[g*16 +: 16] & ~m_mask[g]) != 16'h0)) any = 1'b1;
    return m_glb & any;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [15:0] a, input logic [NCH-1:0] rq);
    logic [31:0] r = '0;
    int g = int'(a[15:12]);
    if (a == 16'hF000) r[0] = m_glb;
    else if (g < NG) begin
      case (a[11:0])
        12'h000: r[15:0] = rq[g*16 +: 16];
        12'h004: r[15:0] = m_mask[g];
        12'h008: r[15:0] = rq[g*16 +: 16] & ~m_mask[g];
        12'h00C: r[20]   = m_ctl[g];
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [31:0] d);
    int g = int'(a[15:12]);
    if (a == 16'hF000) m_glb = d[0];
    else if (g < NG) begin
      if (a[11:0] == 12'h004) m_mask[g] = d[15:0];
      if (a[11:0] == 12'h00C) m_ctl[g]  = d[20];
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // write at a falling edge; register takes it at the next rising edge
  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic read_check(input string tag, input logic [15:0] a);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp_rd(a, chan_req));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int g = 0; g < NG; g++) begin m_mask[g] = 16'hFFFF; m_ctl[g] = 1'b0; end
    m_glb = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 reset state
    chan_req = '1;
    read_check("R3 mask g0", 16'h0004);
    read_check("R3 mask g1", 16'h1004);
    read_check("R3 ctrl g1", 16'h100C);
    read_check("R3 global", 16'hF000);
    check("R3 irq", {31'b0, irq_out}, 32'h0);

    // R1 live status, R4 pending
    chan_req = 32'hA5C3_0F81;
    read_check("R1 status g0", 16'h0000);
    read_check("R1 status g1", 16'h1000);
    bus_write(16'h0004, 32'hFFFF_00F0);
    read_check("R2 mask readback", 16'h0004);
    read_check("R4 pending g0", 16'h0008);

    // R5 only bit 20 stored
    bus_write(16'h000C, 32'hFFFF_FFFF);
    read_check("R5 ctrl bits", 16'h000C);
    check("R6 irq with global off", {31'b0, irq_out}, {31'b0, exp_irq(chan_req)});
    bus_write(16'hF000, 32'hFFFF_FFFF);
    read_check("R6 global bits", 16'hF000);

    // R7 same-cycle follow of requests
    bus_addr = 16'h0000;
    chan_req = 32'h0000_0001;
    #1 check("R7 raise no clock", {31'b0, irq_out}, 32'h1);
    chan_req = 32'h0000_0010;
    #1 check("R7 masked channel", {31'b0, irq_out}, 32'h0);
    chan_req = 32'h0000_0000;
    #1 check("R7 drop no clock", {31'b0, irq_out}, 32'h0);

    // R8 group isolation and read-only views
    bus_write(16'h1004, 32'h0000_1234);
    read_check("R8 g0 mask untouched", 16'h0004);
    read_check("R8 g1 mask", 16'h1004);
    bus_write(16'h0000, 32'h0000_0000);
    bus_write(16'h0008, 32'h0000_0000);
    read_check("R8 status write ignored", 16'h0004);
    read_check("R8 ctrl after ro writes", 16'h000C);

    // R9 unmapped
    chan_req = '1;
    read_check("R9 bad offset", 16'h0010);
    read_check("R9 bad group", 16'h2000);
    read_check("R9 high address", 16'hE004);

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int g, kind;
      logic [11:0] ofs;
      logic [15:0] a;
      logic [31:0] d;
      logic wr;
      @(negedge clk);
      g    = int'($urandom % 3);
      kind = int'($urandom % 6);
      case (kind)
        0: ofs = 12'h000;
        1: ofs = 12'h004;
        2: ofs = 12'h008;
        3: ofs = 12'h00C;
        default: ofs = 12'h010;
      endcase
      a = (kind == 5) ? 16'hF000 : {g[3:0], ofs};
      d = $urandom;
      if (kind == 5) d[0] = (($urandom % 4) != 0);
      if (kind == 1) d = d | ($urandom & $urandom);
      wr = (($urandom % 4) == 0);
      chan_req  = (($urandom % 3) == 0) ? ($urandom & $urandom & $urandom) : $urandom;
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = wr;
      #1;
      check("R7 random irq", {31'b0, irq_out}, {31'b0, exp_irq(chan_req)});
      if (!wr) check("R4 random read", bus_rdata, exp_rd(a, chan_req));
      if (wr) model_write(a, d);
    end
    @(negedge clk);
    bus_wr = 1'b0;

    done = 1'b1;
    finish_run();
  end
endmodule